// File: doc/BRIEF.md
# Asynchronous word framer with bit-centre clock

This block sits behind an FSK demodulator that delivers one bit of line state per system clock at a nominal 1200 baud. It watches that stream for 10-bit asynchronous words: a space start bit, eight data bits sent least significant first, and a mark stop bit. The demodulated level goes straight out on a data pin. A clock pulse appears at the middle of each of the eight data bits, so a plain shift register downstream captures only payload. A data-ready strobe, low for half a bit time, marks the end of each word. The clock count per bit is a parameter, which is 2983 cycles of a 3.579545 MHz system clock by default.

A carrier-valid qualifier gates the whole framer. While carrier is absent, the data pin idles at mark, no pulses are made, and any word in progress is dropped. A power-down input parks the outputs in a quiet state. Data-ready is active low and has a separate output-enable so that a pad can emulate an open-drain pin. The stream has no back-pressure. The block has no ready signal, and the consumer must take every bit and every pulse at the moment it appears. Carrier, power-down and reset are plain level controls.

Top module: `fsk_word_framer`

## Requirements
- R1: After reset `data_o` is 1, `bclk_o` is 0, `dready_n` is 1 and `dready_oe` is 0.
- R2: With carrier present and power-down low, `data_o` equals `rx_bit` delayed by SYNC_STAGES clocks.
- R3: A start bit that has returned to mark when it is re-sampled at mid-bit (CYC_PER_BIT/2 clocks after the falling edge) is a false start. The framer goes back to idle and makes no clock or data-ready pulse.
- R4: A valid word makes exactly 8 rising edges on `bclk_o`. If e0 is the clock edge that first captures the low start level, the k-th rising edge (k = 1..8) follows edge e0 + SYNC_STAGES + CYC_PER_BIT/2 + k*CYC_PER_BIT.
- R5: Each `bclk_o` pulse stays high for PULSE_CYC clocks and falls before the next bit centre.
- R6: `bclk_o` never rises at the centre of a start or stop bit.
- R7: At the stop-bit centre (centre offset + 9*CYC_PER_BIT after e0 + SYNC_STAGES), `dready_n` goes low for CYC_PER_BIT/2 clocks. `dready_oe` is 1 exactly while `dready_n` is 0.
- R8: While `carrier_ok` is 0, `data_o` is 1 and no `bclk_o` or `dready_n` pulse occurs. A pulse already running ends at the first edge that samples carrier low. A bit centre that falls on that same edge is suppressed, and the word in progress is abandoned.
- R9: While `pwdn` is 1, `data_o` and `bclk_o` are 1, `dready_n` is 1 and `dready_oe` is 0. No word is framed.
- R10: Back-to-back words with no idle gap are each framed correctly. One word's data-ready pulse may still be active while the next start bit is being timed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn | input | 1 | Power-down, active high |
| carrier_ok | input | 1 | Carrier-valid qualifier, active high |
| rx_bit | input | 1 | Demodulated line level, 1 = mark |
| data_o | output | 1 | Gated pass-through of the line level |
| bclk_o | output | 1 | Bit-centre clock, data bits only |
| dready_n | output | 1 | End-of-word strobe, active low |
| dready_oe | output | 1 | Drive enable for dready_n |

## Verification
The data-ready pulse of one word and the start-bit qualification of the next can be live at the same time. Back-to-back words provoke this, and the per-clock model must see both the full half-bit strobe and correctly placed clock pulses for the second word. A carrier drop is also timed to land on the very edge of a data-bit centre. The bench then judges that the abort wins: three pulses instead of four, and no data-ready.

// File: rtl/fsk_framer_pkg.sv
package fsk_framer_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_e;
endpackage

// File: rtl/fsk_in_sync.sv
module fsk_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b1;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fsk_bit_sequencer.sv
module fsk_bit_sequencer
  import fsk_framer_pkg::*;
#(
  parameter int CYC_PER_BIT = 2983,
  parameter int DATA_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic line,
  output logic bit_strobe,
  output logic word_strobe
);
  localparam int CENTRE = CYC_PER_BIT / 2;
  localparam int CW     = $clog2(CYC_PER_BIT);
  localparam int IW     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  fr_state_e       state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic            line_q;
  logic            at_bit_end;
  logic            at_centre;

  assign at_bit_end  = (cnt == CW'(CYC_PER_BIT - 1));
  assign at_centre   = (cnt == CW'(CENTRE - 1));
  assign bit_strobe  = (state == FR_DATA) && at_bit_end;
  assign word_strobe = (state == FR_STOP) && at_bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FR_IDLE;
      cnt    <= '0;
      idx    <= '0;
      line_q <= 1'b1;
    end else begin
      line_q <= line;
      if (abort) begin
        state <= FR_IDLE;
        cnt   <= '0;
        idx   <= '0;
      end else begin
        case (state)
          FR_IDLE: begin
            cnt <= '0;
            idx <= '0;
            if (line_q && !line) state <= FR_START;
          end
          FR_START: begin
            if (at_centre) begin
              cnt   <= '0;
              state <= line ? FR_IDLE : FR_DATA;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          FR_DATA: begin
            if (at_bit_end) begin
              cnt <= '0;
              if (idx == IW'(DATA_BITS - 1)) begin
                idx   <= '0;
                state <= FR_STOP;
              end else begin
                idx <= idx + IW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          FR_STOP: begin
            if (at_bit_end) begin
              cnt   <= '0;
              state <= FR_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end

  // R8: once aborted, no bit or word centre may be flagged on the next cycle
  assert_abort_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!bit_strobe && !word_strobe));

  // R3: a start bit found at mark on its mid-bit sample returns to idle
  assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_START && at_centre && line && !abort) |=> (state == FR_IDLE));

  // R6: the last data centre hands over to the stop bit, never to another data bit
  assert_eighth_bit_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && idx == IW'(DATA_BITS - 1) && !abort) |=> (state == FR_STOP));
endmodule

// File: rtl/fsk_pulse_timer.sv
module fsk_pulse_timer #(
  parameter int WIDTH_CYC = 746
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic fire,
  output logic active
);
  localparam int TW = $clog2(WIDTH_CYC + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (abort)          left <= '0;
    else if (fire)           left <= TW'(WIDTH_CYC);
    else if (left != '0)     left <= left - TW'(1);
  end

  assign active = (left != '0);

  // R5: a pulse must have ended before the next one is requested
  assert_pulse_clear_before_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !abort) |-> !active);
endmodule

// File: rtl/fsk_word_framer.sv
module fsk_word_framer #(
  parameter int CYC_PER_BIT = 2983,
  parameter int PULSE_CYC   = 746,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic carrier_ok,
  input  logic rx_bit,
  output logic data_o,
  output logic bclk_o,
  output logic dready_n,
  output logic dready_oe
);
  localparam int HALF_BIT  = CYC_PER_BIT / 2;
  localparam int DATA_BITS = 8;

  logic line;
  logic abort;
  logic bit_strobe;
  logic word_strobe;
  logic clk_pulse;
  logic dr_pulse;

  assign abort = pwdn || !carrier_ok;

  fsk_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_bit), .q(line)
  );

  fsk_bit_sequencer #(.CYC_PER_BIT(CYC_PER_BIT), .DATA_BITS(DATA_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort), .line(line),
    .bit_strobe(bit_strobe), .word_strobe(word_strobe)
  );

  fsk_pulse_timer #(.WIDTH_CYC(PULSE_CYC)) u_clk_pulse (
    .clk(clk), .rst_n(rst_n), .abort(abort), .fire(bit_strobe), .active(clk_pulse)
  );

  fsk_pulse_timer #(.WIDTH_CYC(HALF_BIT)) u_dr_pulse (
    .clk(clk), .rst_n(rst_n), .abort(abort), .fire(word_strobe), .active(dr_pulse)
  );

  assign data_o    = line || abort;
  assign bclk_o    = pwdn || clk_pulse;
  assign dready_n  = pwdn || !dr_pulse;
  assign dready_oe = !pwdn && dr_pulse;

  // R9: power-down empties both pulse timers by the following cycle
  assert_pwdn_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |=> (!clk_pulse && !dr_pulse));

  // R6: a data-bit centre and a stop-bit centre never coincide
  assert_no_centre_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_strobe && word_strobe));
endmodule

// File: tb/test_fsk_word_framer.sv
module test_fsk_word_framer;
  localparam int CYC    = 40;
  localparam int PULSE  = 10;
  localparam int SYNC   = 2;
  localparam int CENTRE = CYC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwdn = 1'b0;
  logic carrier_ok = 1'b1;
  logic rx_in = 1'b1;
  logic data_o, bclk_o, dready_n, dready_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bq[$];
  int dq[$];
  logic hist[$];
  string tag_now = "R1";
  int rise_cnt = 0;
  int dr_cnt = 0;
  logic bclk_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsk_word_framer #(.CYC_PER_BIT(CYC), .PULSE_CYC(PULSE), .SYNC_STAGES(SYNC)) i_fsk_word_framer (
    .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .carrier_ok(carrier_ok), .rx_bit(rx_in),
    .data_o(data_o), .bclk_o(bclk_o), .dready_n(dready_n), .dready_oe(dready_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag_now, what, cyc, act, exp);
    end
  endtask

  // reference model: edge index bookkeeping and abort handling
  always @(posedge clk) begin
    cyc = cyc + 1;
    hist.push_back(rx_in);
    if (hist.size() > 4) void'(hist.pop_front());
    if (rst_n && (!carrier_ok || pwdn)) begin
      bq.delete();
      dq.delete();
    end
  end

  always @(negedge clk) begin
    logic eb, ed, edata;
    eb = 1'b0;
    ed = 1'b0;
    foreach (bq[i]) if (bq[i] <= cyc && cyc < bq[i] + PULSE) eb = 1'b1;
    foreach (dq[i]) if (dq[i] <= cyc && cyc < dq[i] + CENTRE) ed = 1'b1;
    if (pwdn || !carrier_ok) edata = 1'b1;
    else if (hist.size() >= SYNC) edata = hist[hist.size() - SYNC];
    else edata = 1'b1;
    if (!rst_n) begin eb = 1'b0; ed = 1'b0; edata = 1'b1; end
    if (pwdn) begin eb = 1'b1; ed = 1'b0; end
    if (!done) begin
      chk(data_o === edata, "data_o (R2)", data_o, edata);
      chk(bclk_o === eb, "bclk_o (R4 R5 R6)", bclk_o, eb);
      chk(dready_n === !ed, "dready_n (R7)", dready_n, !ed);
      chk(dready_oe === ed, "dready_oe (R7)", dready_oe, ed);
    end
    if (!pwdn && bclk_o && !bclk_prev) rise_cnt++;
    if (!dready_n) dr_cnt++;
    bclk_prev = bclk_o;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_word(input logic [7:0] b, input bit expect_it);
    int e0, d0;
    e0 = cyc + 1;
    d0 = e0 + SYNC + CENTRE;
    if (expect_it) begin
      for (int k = 1; k <= 8; k++) bq.push_back(d0 + k * CYC);
      dq.push_back(d0 + 9 * CYC);
    end
    rx_in = 1'b0;
    tick(CYC);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      tick(CYC);
    end
    rx_in = 1'b1;
    tick(CYC);
  endtask

  task automatic word_check(input logic [7:0] b, input int exp_rise, input int exp_dr);
    rise_cnt = 0;
    dr_cnt = 0;
    send_word(b, 1'b1);
    tick(CENTRE + 4);
    chk(rise_cnt == exp_rise, "bclk rising edges per word (R4)", rise_cnt, exp_rise);
    chk(dr_cnt == exp_dr, "dready low cycles (R7)", dr_cnt, exp_dr);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R4)");
    finish_run();
  end

  initial begin
    tick(5);
    tag_now = "R1";
    chk(data_o === 1'b1 && bclk_o === 1'b0, "reset data/bclk (R1)", {data_o, bclk_o}, 2'b10);
    chk(dready_n === 1'b1 && dready_oe === 1'b0, "reset dready (R1)", {dready_n, dready_oe}, 2'b10);
    rst_n = 1'b1;
    tick(10);

    tag_now = "R4";
    word_check(8'hA5, 8, CENTRE);
    tick(CYC);
    word_check(8'h00, 8, CENTRE);
    tick(CYC);
    word_check(8'hFF, 8, CENTRE);
    tick(CYC);

    tag_now = "R10";
    rise_cnt = 0;
    dr_cnt = 0;
    send_word(8'h3C, 1'b1);
    send_word(8'hC3, 1'b1);
    tick(CENTRE + 4);
    chk(rise_cnt == 16, "back-to-back rising edges (R10)", rise_cnt, 16);
    chk(dr_cnt == 2 * CENTRE, "back-to-back dready cycles (R10)", dr_cnt, 2 * CENTRE);
    tick(CYC);

    tag_now = "R3";
    rise_cnt = 0;
    dr_cnt = 0;
    rx_in = 1'b0;
    tick(CENTRE / 2);
    rx_in = 1'b1;
    tick(12 * CYC);
    chk(rise_cnt == 0, "false start bclk (R3)", rise_cnt, 0);
    chk(dr_cnt == 0, "false start dready (R3)", dr_cnt, 0);
    word_check(8'h81, 8, CENTRE);
    tick(CYC);

    tag_now = "R8";
    rise_cnt = 0;
    dr_cnt = 0;
    fork
      send_word(8'h5A, 1'b1);
      begin
        tick(SYNC + CENTRE + 4 * CYC);
        carrier_ok = 1'b0;
      end
    join
    tick(CYC);
    chk(rise_cnt == 3, "bclk edges before carrier loss (R8)", rise_cnt, 3);
    chk(dr_cnt == 0, "dready after carrier loss (R8)", dr_cnt, 0);
    chk(data_o === 1'b1, "data_o without carrier (R8)", data_o, 1);
    rise_cnt = 0;
    send_word(8'h0F, 1'b0);
    chk(rise_cnt == 0, "word without carrier (R8)", rise_cnt, 0);
    carrier_ok = 1'b1;
    tick(CYC);
    word_check(8'h66, 8, CENTRE);
    tick(CYC);

    tag_now = "R9";
    pwdn = 1'b1;
    tick(3);
    chk(data_o === 1'b1 && bclk_o === 1'b1, "power-down data/bclk (R9)", {data_o, bclk_o}, 2'b11);
    chk(dready_n === 1'b1 && dready_oe === 1'b0, "power-down dready (R9)", {dready_n, dready_oe}, 2'b10);
    dr_cnt = 0;
    send_word(8'h42, 1'b0);
    chk(dr_cnt == 0, "power-down word (R9)", dr_cnt, 0);
    pwdn = 1'b0;
    tick(CYC);
    tag_now = "R2";
    word_check(8'h99, 8, CENTRE);
    tick(CYC);
    finish_run();
  end
endmodule